// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block turns single-byte requests from an internal clocked port into correctly timed access cycles on an external asynchronous static RAM of 1M words by 8 bits. A request carries a read/write flag, a 20-bit word address and a write byte. The request port uses valid/ready. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the controller is idle, so back-pressure lasts for the whole access including its recovery. Read data comes back on `rd_data` with a one-cycle `rd_valid` pulse. There is no back-pressure on the return path.

On the memory side the controller drives a select that is active low and a select that is active high. Both must be active for the memory to respond. It also drives an active-low write strobe and an active-low output enable. The data bus is split into an output byte, a drive enable and an input byte, so that the pad ring can build the tristate pin. The memory's timing minimums are given in nanoseconds as parameters, together with the clock period. Each one is turned into a cycle count by dividing by the clock period and rounding up. Between accesses both selects are held inactive.

A write keeps the output enable high throughout. Its address is set up one phase before the write strobe falls. The strobe stays low long enough for both the pulse-width minimum and the data-setup minimum. The data and address are then held one phase beyond the strobe's rising edge. A read is followed by a turnaround phase. In that phase the memory is deselected long enough for it to release the bus before the controller may drive the bus again.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle the controller is idle: `req_ready`=1, `mem_sel_n`=1, `mem_sel_h`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_dout_en`=0 and `rd_valid`=0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance and stays 0 until the access and its recovery are over. A request held during that time is not taken a second time.
- R3: A read drives `mem_sel_n`=0, `mem_sel_h`=1, `mem_wr_n`=1, `mem_rd_n`=0 and `mem_dout_en`=0 for RD_N cycles, beginning at the acceptance edge. RD_N is the largest of the rounded-up cycle counts for address access, output-enable access and read cycle time (7 at the defaults).
- R4: `rd_valid` is 1 for exactly one cycle, starting RD_N edges after acceptance. `rd_data` then holds the byte sampled from `mem_din` in the last read cycle. That byte is the value most recently written to that address.
- R5: After a read, the memory is deselected with `mem_rd_n`=1 for TURN_N = ceil(output-disable time / clock) cycles (3 at the defaults). `req_ready` returns RD_N+TURN_N edges after acceptance.
- R6: A write has three phases. First, SET_N cycles (1) with both selects active and `mem_wr_n`=1. Next, PULSE_N cycles (4) with `mem_wr_n`=0; PULSE_N is the larger of the rounded pulse-width and data-setup counts. Last, HOLD_N cycles (2) with `mem_wr_n`=1. The three phases together cover at least the write cycle time. `req_ready` returns SET_N+PULSE_N+HOLD_N edges after acceptance.
- R7: `mem_rd_n` stays 1 during a whole write. `mem_dout_en` is 1 only during the pulse and hold phases of a write. It is never 1 while `mem_rd_n` is 0, nor within the output-disable time after `mem_rd_n` rises.
- R8: `mem_addr` changes only while `mem_wr_n` is 1. Two address changes are at least one cycle time apart.
- R9: `mem_dout` equals the write byte and is driven for at least the data-setup time before `mem_wr_n` rises. The byte is then stored at the request address.
- R10: `mem_wr_n` is 0 only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 8 | Read byte |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_sel_h | output | 1 | Memory select, active high |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Output enable, active low |
| mem_dout | output | 8 | Byte to drive on the memory bus |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 8 | Byte read from the memory bus |

## Verification
The bench's memory model returns a poison byte until the full address access time has passed. A read window shortened by even one cycle therefore returns the wrong data rather than silently passing. The model times write strobe width, data setup before the strobe's rising edge, address hold time and bus drive after an output disable, all against the nanosecond minimums. So a write pulse cut short, data driven too late, or a turnaround phase that is skipped each show up as a timing failure. A request held high through a busy period, with a different write byte, catches a controller that takes the request twice, because a later readback returns the wrong byte. Back-to-back mixes of reads and writes at address zero and at the top address check that each new address appears only while the strobe is high.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_RD_TURN,
    PH_WR_SET,
    PH_WR_PULSE,
    PH_WR_HOLD
  } ph_e;

  typedef struct packed {
    logic sel_n;
    logic sel_h;
    logic wr_n;
    logic rd_n;
    logic dout_en;
  } pins_t;

  function automatic int cdiv(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels for each phase; pins are registered from the next phase.
  function automatic pins_t pins_for(input ph_e ph);
    pins_t p;
    p = '{sel_n: 1'b1, sel_h: 1'b0, wr_n: 1'b1, rd_n: 1'b1, dout_en: 1'b0};
    case (ph)
      PH_RD:       p = '{sel_n: 1'b0, sel_h: 1'b1, wr_n: 1'b1, rd_n: 1'b0, dout_en: 1'b0};
      PH_WR_SET:   p = '{sel_n: 1'b0, sel_h: 1'b1, wr_n: 1'b1, rd_n: 1'b1, dout_en: 1'b0};
      PH_WR_PULSE: p = '{sel_n: 1'b0, sel_h: 1'b1, wr_n: 1'b0, rd_n: 1'b1, dout_en: 1'b1};
      PH_WR_HOLD:  p = '{sel_n: 1'b0, sel_h: 1'b1, wr_n: 1'b1, rd_n: 1'b1, dout_en: 1'b1};
      default:     ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW      = 3,
  parameter int RD_N    = 7,
  parameter int TURN_N  = 3,
  parameter int SET_N   = 1,
  parameter int PULSE_N = 4,
  parameter int HOLD_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_expired,
  output ph_e           ph_d,
  output logic          idle,
  output logic          accept,
  output logic          capture,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  localparam logic [CW-1:0] RD_L    = CW'(RD_N - 1);
  localparam logic [CW-1:0] TURN_L  = CW'(TURN_N - 1);
  localparam logic [CW-1:0] SET_L   = CW'(SET_N - 1);
  localparam logic [CW-1:0] PULSE_L = CW'(PULSE_N - 1);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_N - 1);

  ph_e ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_comb begin
    ph_d     = ph_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          ph_d    = PH_WR_SET;
          tmr_val = SET_L;
        end else begin
          ph_d    = PH_RD;
          tmr_val = RD_L;
        end
      end
      PH_RD: if (tmr_expired) begin
        capture  = 1'b1;
        ph_d     = PH_RD_TURN;
        tmr_load = 1'b1;
        tmr_val  = TURN_L;
      end
      PH_RD_TURN: if (tmr_expired) ph_d = PH_IDLE;
      PH_WR_SET: if (tmr_expired) begin
        ph_d     = PH_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = PULSE_L;
      end
      PH_WR_PULSE: if (tmr_expired) begin
        ph_d     = PH_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_L;
      end
      PH_WR_HOLD: if (tmr_expired) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign idle = (ph_q == PH_IDLE);
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ph_e           ph_d,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_din,
  output pins_t         pins,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins     <= pins_for(PH_IDLE);
      mem_addr <= '0;
      mem_dout <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pins     <= pins_for(ph_d);
      rd_valid <= capture;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (capture) rd_data <= mem_din;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_OHZ  = 30,
  parameter int T_WC   = 70,
  parameter int T_WP   = 35,
  parameter int T_DW   = 30,
  parameter int T_AS   = 0,
  parameter int T_WR   = 0,
  parameter int T_DH   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel_h,
  output logic          mem_wr_n,
  output logic          mem_rd_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);
  localparam int RD_N    = imax(1, imax(cdiv(T_AA, CLK_NS),
                                        imax(cdiv(T_RC, CLK_NS), cdiv(T_OE, CLK_NS))));
  localparam int TURN_N  = imax(1, cdiv(T_OHZ, CLK_NS));
  localparam int SET_N   = imax(1, cdiv(T_AS, CLK_NS));
  localparam int PULSE_N = imax(1, imax(cdiv(T_WP, CLK_NS), cdiv(T_DW, CLK_NS)));
  localparam int HOLD_N  = imax(imax(1, cdiv(T_DH, CLK_NS)),
                                imax(cdiv(T_WR, CLK_NS), cdiv(T_WC, CLK_NS) - SET_N - PULSE_N));
  localparam int MAX_N   = imax(imax(RD_N, TURN_N), imax(PULSE_N, imax(SET_N, HOLD_N)));
  localparam int CW      = imax(1, $clog2(MAX_N + 1));

  ph_e           ph_d;
  pins_t         pins;
  logic          idle, accept, capture, tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_seq #(
    .CW(CW), .RD_N(RD_N), .TURN_N(TURN_N), .SET_N(SET_N), .PULSE_N(PULSE_N), .HOLD_N(HOLD_N)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_expired(tmr_expired), .ph_d(ph_d), .idle(idle), .accept(accept),
    .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_pin_reg #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .ph_d(ph_d), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_din(mem_din), .pins(pins),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ready   = idle;
  assign mem_sel_n   = pins.sel_n;
  assign mem_sel_h   = pins.sel_h;
  assign mem_wr_n    = pins.wr_n;
  assign mem_rd_n    = pins.rd_n;
  assign mem_dout_en = pins.dout_en;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel_h,
  input logic          mem_wr_n,
  input logic          mem_rd_n,
  input logic          mem_dout_en
);
  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel_h && mem_wr_n && mem_rd_n && !mem_dout_en));

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_rd_n);

  // R7
  rd_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_rd_n && mem_dout_en));

  // R8
  addr_stable_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> $stable(mem_addr));

  // R10
  wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_sel_n && mem_sel_h));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
  .mem_sel_h(mem_sel_h), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
  .mem_dout_en(mem_dout_en)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int CLK = 10;
  localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_OHZ = 30;
  localparam int T_WC = 70, T_WP = 35, T_DW = 30;
  localparam logic [7:0] POISON = 8'hA7;

  function automatic int up(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD    = mx(up(T_AA), mx(up(T_RC), up(T_OE)));
  localparam int E_TURN  = mx(1, up(T_OHZ));
  localparam int E_SET   = 1;
  localparam int E_PULSE = mx(up(T_WP), up(T_DW));
  localparam int E_HOLD  = mx(1, up(T_WC) - E_SET - E_PULSE);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel_h, mem_wr_n, mem_rd_n, mem_dout_en;
  logic [7:0] rd_data, mem_dout, mem_din;
  logic [19:0] mem_addr;

  int checks = 0, errors = 0;

  always #(CLK/2) clk = ~clk;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel_h(mem_sel_h), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model with timing checks ----------------
  logic [7:0] store [logic [19:0]];
  realtime t_acc = 0, t_addr = -1000, t_wfall = 0, t_dchg = 0, t_rdrise = -1000;
  bit first_addr = 1'b1;
  wire selected = !mem_sel_n && mem_sel_h;

  always @(mem_addr or mem_sel_n or mem_sel_h or mem_rd_n or mem_wr_n) t_acc = $realtime;
  always @(mem_dout or mem_dout_en) t_dchg = $realtime;
  always @(negedge mem_wr_n) t_wfall = $realtime;
  always @(posedge mem_rd_n) t_rdrise = $realtime;

  always @(mem_addr) if (rst_n) begin
    // R8: address moves only with write strobe high, one cycle time apart
    chk(mem_wr_n === 1'b1, "R8 addr change under write strobe", 32'(mem_wr_n), 1);
    if (!first_addr)
      chk(($realtime - t_addr) >= T_WC, "R8 addr hold time", 32'(int'($realtime - t_addr)), T_WC);
    first_addr = 1'b0;
    t_addr = $realtime;
  end

  always @(posedge mem_wr_n) if (rst_n && selected) begin
    chk(($realtime - t_wfall) >= T_WP, "R6 write pulse width", 32'(int'($realtime - t_wfall)), T_WP);
    chk(mem_dout_en && (($realtime - t_dchg) >= T_DW), "R9 data setup before strobe end",
        32'(int'($realtime - t_dchg)), T_DW);
    store[mem_addr] = mem_dout;
  end

  always @(posedge mem_dout_en) if (rst_n)
    chk(mem_rd_n && (($realtime - t_rdrise) >= T_OHZ), "R7 drive after output disable",
        32'(int'($realtime - t_rdrise)), T_OHZ);

  initial begin
    mem_din = POISON;
    #0.5;
    forever begin
      if (selected && !mem_rd_n && mem_wr_n && ($realtime - t_acc) >= (T_AA - 1))
        mem_din = store.exists(mem_addr) ? store[mem_addr] : 8'h00;
      else
        mem_din = POISON;
      #1;
    end
  end

  // ---------------- expected contents ----------------
  logic [7:0] expm [logic [19:0]];

  function automatic logic [7:0] exp_rd(input logic [19:0] a);
    return expm.exists(a) ? expm[a] : 8'h00;
  endfunction

  task automatic do_op(input bit wr, input logic [19:0] a, input logic [7:0] d, input bit hold);
    bit pins_ok, rv_ok, data_ok;
    int k, total;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    total = wr ? (E_SET + E_PULSE + E_HOLD) : (E_RD + E_TURN);
    pins_ok = 1'b1; rv_ok = 1'b1; data_ok = 1'b1; got = '0;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        // R2: ready drops after acceptance
        chk(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
        if (hold) begin
          req_write = 1'b1; req_wdata = ~d;
        end else req_valid = 1'b0;
      end
      if (req_ready) begin
        req_valid = 1'b0;
        break;
      end
      if (k > 40) break;
      if (!wr) begin
        if (k <= E_RD)
          pins_ok &= (!mem_sel_n && mem_sel_h && mem_wr_n && !mem_rd_n && !mem_dout_en);
        else
          pins_ok &= (mem_sel_n && !mem_sel_h && mem_rd_n && mem_wr_n && !mem_dout_en);
        if (k == E_RD + 1) begin
          rv_ok &= rd_valid; got = rd_data;
        end else rv_ok &= !rd_valid;
      end else begin
        pins_ok &= (!mem_sel_n && mem_sel_h && mem_rd_n && !rd_valid);
        if (k <= E_SET)
          pins_ok &= (mem_wr_n && !mem_dout_en);
        else if (k <= E_SET + E_PULSE)
          pins_ok &= (!mem_wr_n && mem_dout_en && mem_dout == d);
        else
          pins_ok &= (mem_wr_n && mem_dout_en && mem_dout == d);
      end
    end
    if (!wr) begin
      chk(pins_ok, "R3/R5 read pin sequence", 32'(pins_ok), 1);
      chk(rv_ok, "R4 rd_valid single pulse timing", 32'(rv_ok), 1);
      chk(got == exp_rd(a), "R4 read data", 32'(got), 32'(exp_rd(a)));
      chk(k == total + 1, "R5 ready return after read", 32'(k), 32'(total + 1));
    end else begin
      chk(pins_ok, "R6/R7 write pin sequence", 32'(pins_ok), 1);
      chk(k == total + 1, "R6 ready return after write", 32'(k), 32'(total + 1));
      expm[a] = d;
    end
    // R1: idle pin levels
    chk(mem_sel_n && !mem_sel_h && mem_wr_n && mem_rd_n && !mem_dout_en && !rd_valid,
        "R1 idle pins", {27'd0, mem_sel_n, mem_sel_h, mem_wr_n, mem_rd_n, mem_dout_en}, 32'b10110);
    if (data_ok) ;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && mem_sel_n && !mem_sel_h && mem_wr_n && mem_rd_n && !mem_dout_en && !rd_valid,
        "R1 reset state", {26'd0, req_ready, mem_sel_n, mem_sel_h, mem_wr_n, mem_rd_n, mem_dout_en}, 32'b110110);

    // directed corners: bottom and top addresses, unwritten read, back-pressure
    do_op(1'b0, 20'h00123, 8'h00, 1'b0);
    do_op(1'b1, 20'h00000, 8'h3C, 1'b0);
    do_op(1'b1, 20'hFFFFF, 8'hC3, 1'b0);
    do_op(1'b0, 20'h00000, 8'h00, 1'b0);
    do_op(1'b0, 20'hFFFFF, 8'h00, 1'b0);
    // R2: write held valid through busy period with another byte; must land once
    do_op(1'b1, 20'h0ABCD, 8'h55, 1'b1);
    do_op(1'b0, 20'h0ABCD, 8'h00, 1'b0);
    // R2: read held valid through busy with a write request to same address
    do_op(1'b0, 20'h0ABCD, 8'h00, 1'b1);
    do_op(1'b0, 20'h0ABCD, 8'h00, 1'b0);
    // R9: write after read on same address, overwrite
    do_op(1'b1, 20'h0ABCD, 8'h12, 1'b0);
    do_op(1'b0, 20'h0ABCD, 8'h00, 1'b0);

    for (int i = 0; i < 200; i++) begin
      logic [19:0] a;
      logic [7:0]  d;
      int unsigned sel;
      sel = $urandom % 4;
      case (sel)
        0: a = 20'h00000;
        1: a = 20'hFFFFF;
        2: a = 20'(($urandom % 16) + 20'h00400);
        default: a = 20'($urandom);
      endcase
      d = 8'($urandom);
      if (d == POISON) d = d ^ 8'h01;
      do_op(($urandom % 2) == 1, a, d, ($urandom % 8) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule